// File: doc/BRIEF.md
# Byte-Wide Circular Operand Stack

This block holds the operands of an arithmetic coprocessor. A host reaches it one byte at a time over an 8-bit bus: a write strobe with the chip select and the data/command select both low places a new byte on top. A read strobe under the same selects shows the top byte on the bus and then removes it. A removed byte is not lost. It moves to the bottom of the stack, so a full round of reads brings the stack back to where it started. A push that is made while the stack is full of valid data drops the byte at the bottom.

The storage is a ring of `DEPTH` bytes indexed by a top pointer. The arithmetic engine reads a parallel window of the top `WIN_BYTES` bytes. With the default sizes, the window holds two 32-bit words (A over B) or four 16-bit words. Multi-byte values are pushed least significant byte first, so they read back most significant byte first. An external busy input freezes the stack while the engine owns it.

Top module: `byte_rot_stack`

## Requirements
- R1: A push stores the bus byte as the new top of stack. A pop returns the most recently pushed byte that has not yet been popped (last in, first out).
- R2: With DEPTH bytes in the ring, a push drops the byte that was deepest. After DEPTH+1 pushes, DEPTH pops return only the last DEPTH bytes written, newest first.
- R3: A pop moves the top byte to the bottom. DEPTH consecutive pops return every stored byte once, and a second round of DEPTH pops returns the same sequence again.
- R4: `bus_oe` is 1 exactly while `cs_n` and `rd_n` are both low. While it is 1, `bus_rdata` carries the current top byte. A read strobe with `cs_n` high changes nothing.
- R5: Each strobe acts once, however many cycles it is held low. The action takes effect in the clock edge at which the strobe is seen released.
- R6: A strobe whose release is seen while `busy` is 1 leaves the stack and the window unchanged.
- R7: Reset (`rst_n` low, synchronous) leaves the stored bytes unchanged and returns the top pointer to slot 0.
- R8: `top_win` shows the top WIN_BYTES bytes. The top byte is in the most significant byte lane, and each lower lane holds the next deeper byte. With the defaults, bits [63:32] form 32-bit word A and bits [31:0] form word B.
- R9: Strobes with `sel_cmd` high (the command/status select) neither push nor pop.
- R10: During and right after reset, `bus_oe` is 0 while the bus strobes are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sel_cmd | input | 1 | 0 selects stack data, 1 selects command/status |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| busy | input | 1 | Engine busy; stack accesses ignored while 1 |
| bus_wdata | input | BYTE_W | Byte written by the host |
| bus_rdata | output | BYTE_W | Top-of-stack byte for the host |
| bus_oe | output | 1 | Bus drive enable |
| top_win | output | WIN_BYTES*BYTE_W | Parallel window of the top bytes for the engine |

## Verification
The bench builds the block with its defaults: a 16-byte ring and an 8-byte window. With only 16 slots, a full circle of pops and the loss of the bottom byte on a 17th push both fit in a few hundred cycles. The 8-byte window covers the whole of both 32-bit words A and B, so every window comparison checks the word view together with the byte view.

// File: rtl/stk_pkg.sv
// Package: shared sizes and the ring-index helpers for the byte stack.
// Assumes: ring depth needs no power-of-two restriction; wrap is explicit.
package stk_pkg;

    localparam int unsigned DEF_BYTE_W = 8;
    localparam int unsigned DEF_DEPTH  = 16;

    // Kind of stack action decoded from the host strobes.
    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_PUSH = 2'b01,
        ACT_POP  = 2'b10
    } stk_act_e;

endpackage

// File: rtl/stk_host_if.sv
// Module: stk_host_if
// Turns host strobes into single-cycle push/pop requests. An action fires
// on the cycle a strobe (with chip select and data select low) is seen
// released, so the top byte stays on the bus for the whole read strobe.
// Assumes: host strobes are synchronous to clk; busy holds actions off.
module stk_host_if #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sel_cmd,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              busy,
    input  logic [BYTE_W-1:0] wdata,
    output stk_pkg::stk_act_e act,
    output logic [BYTE_W-1:0] push_byte
);
    import stk_pkg::*;

    logic wr_sel, rd_sel;
    logic wr_sel_q, rd_sel_q;
    logic [BYTE_W-1:0] wdata_q;

    assign wr_sel = !cs_n && !sel_cmd && !wr_n;
    assign rd_sel = !cs_n && !sel_cmd && !rd_n;

    // Remember last cycle's selects and the byte held during a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel_q <= 1'b0;
            rd_sel_q <= 1'b0;
            wdata_q  <= '0;
        end else begin
            wr_sel_q <= wr_sel;
            rd_sel_q <= rd_sel;
            if (wr_sel) wdata_q <= wdata;
        end
    end

    // Decode the release of a strobe into one action; pushes win a tie.
    always_comb begin
        act = ACT_NONE;
        if (!busy) begin
            if (wr_sel_q && !wr_sel)      act = ACT_PUSH;
            else if (rd_sel_q && !rd_sel) act = ACT_POP;
        end
    end

    assign push_byte = wdata_q;

    AST_ONE_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (act != ACT_NONE) |=> (act == ACT_NONE)); // R5

endmodule

// File: rtl/stk_ptr.sv
// Module: stk_ptr
// Holds the top-of-stack pointer of the ring. A push moves it one slot
// down (with wrap) and names that slot for the write; a pop moves it up.
// Assumes: at most one action per cycle; reset returns it to slot 0.
module stk_ptr #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_pkg::stk_act_e act,
    output logic [PTR_W-1:0]  top_ptr,
    output logic [PTR_W-1:0]  push_slot
);
    import stk_pkg::*;

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] up_slot;

    // Neighbour slots of the top with explicit wrap at the ring ends.
    always_comb begin
        push_slot = (top_ptr == '0)   ? LAST : top_ptr - 1'b1;
        up_slot   = (top_ptr == LAST) ? '0   : top_ptr + 1'b1;
    end

    // Move the pointer on each action; reset parks it on slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n)               top_ptr <= '0;
        else if (act == ACT_PUSH) top_ptr <= push_slot;
        else if (act == ACT_POP)  top_ptr <= up_slot;
    end

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_PUSH) |=> (top_ptr == (($past(top_ptr) == '0) ? LAST
                                           : $past(top_ptr) - 1'b1))); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NONE) |=> $stable(top_ptr)); // R5

endmodule

// File: rtl/stk_mem.sv
// Module: stk_mem
// Byte storage of the ring and the parallel window read by the engine.
// The slot at the pointer lands in the top byte lane, deeper slots below.
// Assumes: storage is never cleared, so reset leaves the contents alone.
module stk_mem #(
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned WIN_BYTES = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned WIN_W = WIN_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_pkg::stk_act_e act,
    input  logic [PTR_W-1:0]  top_ptr,
    input  logic [PTR_W-1:0]  push_slot,
    input  logic [BYTE_W-1:0] push_byte,
    output logic [WIN_W-1:0]  win
);
    import stk_pkg::*;

    logic [BYTE_W-1:0] cells [DEPTH];

    // Write the pushed byte into the slot above the old top.
    always_ff @(posedge clk) begin
        if (act == ACT_PUSH) cells[push_slot] <= push_byte;
    end

    // One window lane per byte, each reading the slot i places below top.
    for (genvar i = 0; i < int'(WIN_BYTES); i++) begin : g_lane
        logic [PTR_W-1:0] slot;
        assign slot = PTR_W'((32'(top_ptr) + 32'(i)) % DEPTH);
        assign win[WIN_W-1-i*BYTE_W -: BYTE_W] = cells[slot];
    end

    AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_PUSH) |=> (win[WIN_W-1 -: BYTE_W] == $past(push_byte))); // R1

endmodule

// File: rtl/byte_rot_stack.sv
// Module: byte_rot_stack (top)
// Byte-wide circular operand stack with host bus access and a parallel
// window for the arithmetic engine. Pops rotate bytes to the bottom.
// Assumes: status and command paths sit outside; they own sel_cmd=1 reads.
module byte_rot_stack #(
    parameter int unsigned BYTE_W    = stk_pkg::DEF_BYTE_W,
    parameter int unsigned DEPTH     = stk_pkg::DEF_DEPTH,
    parameter int unsigned WIN_BYTES = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned WIN_W = WIN_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sel_cmd,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              busy,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_oe,
    output logic [WIN_W-1:0]  top_win
);
    import stk_pkg::*;

    stk_act_e          act;
    logic [BYTE_W-1:0] push_byte;
    logic [PTR_W-1:0]  top_ptr;
    logic [PTR_W-1:0]  push_slot;

    stk_host_if #(.BYTE_W(BYTE_W)) u_host (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel_cmd(sel_cmd),
        .wr_n(wr_n), .rd_n(rd_n), .busy(busy), .wdata(bus_wdata),
        .act(act), .push_byte(push_byte)
    );

    stk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .act(act),
        .top_ptr(top_ptr), .push_slot(push_slot)
    );

    stk_mem #(.BYTE_W(BYTE_W), .DEPTH(DEPTH), .WIN_BYTES(WIN_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .act(act), .top_ptr(top_ptr),
        .push_slot(push_slot), .push_byte(push_byte), .win(top_win)
    );

    // Host sees the top byte; the bus is driven only under select and read.
    assign bus_rdata = top_win[WIN_W-1 -: BYTE_W];
    assign bus_oe    = !cs_n && !rd_n;

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(top_win)); // R6

endmodule

// File: tb/byte_rot_stack_bench.sv
module byte_rot_stack_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, cs_n = 1'b1, sel_cmd = 1'b0, wr_n = 1'b1, rd_n = 1'b1, busy = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_oe;
    logic [63:0] top_win;

    byte_rot_stack u_byte_rot_stack (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel_cmd(sel_cmd), .wr_n(wr_n),
        .rd_n(rd_n), .busy(busy), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_oe(bus_oe), .top_win(top_win)
    );

    logic [7:0] model[$];
    logic [7:0] exp_q[$];
    int checks = 0, errors = 0;
    bit done = 0;
    bit mon_prev = 0;
    string cur_req = "R1";

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: push one byte, strobe held 'hold' cycles.
    task automatic do_push(logic [7:0] b, int hold = 1, bit bz = 0, bit cmd = 0);
        @(posedge clk); #2;
        cs_n = 0; sel_cmd = cmd; wr_n = 0; bus_wdata = b; busy = bz;
        repeat (hold) @(posedge clk);
        #2; wr_n = 1; cs_n = 1;
        @(posedge clk); #2;
        busy = 0; sel_cmd = 0;
        if (!bz && !cmd) begin
            model.push_front(b);
            void'(model.pop_back());
        end
    endtask

    // Driver: pop one byte; queues the expected byte for the monitor.
    task automatic do_pop(string req, int hold = 1, bit bz = 0);
        @(posedge clk); #2;
        cur_req = req;
        exp_q.push_back(model[0]);
        cs_n = 0; sel_cmd = 0; rd_n = 0; busy = bz;
        repeat (hold) @(posedge clk);
        #2; rd_n = 1; cs_n = 1;
        @(posedge clk); #2;
        busy = 0;
        if (!bz) begin
            logic [7:0] t;
            t = model.pop_front();
            model.push_back(t);
        end
    endtask

    task automatic check_win(string req);
        logic [63:0] e;
        @(negedge clk);
        e = '0;
        for (int i = 0; i < 8; i++) e = {e[55:0], model[i]};
        check(req, top_win, e);
    endtask

    task automatic do_reset();
        @(posedge clk); #2; rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 oe in reset", 64'(bus_oe), 64'd0);
        @(posedge clk); #2; rst_n = 1;
    endtask

    // Monitor: on the first cycle of each data read, compare bus to queue.
    always @(negedge clk) begin
        bit rd_now;
        rd_now = !cs_n && !sel_cmd && !rd_n && rst_n;
        if (rd_now && !mon_prev) begin
            check({cur_req, " oe"}, 64'(bus_oe), 64'd1);
            if (exp_q.size() == 0) check({cur_req, " queue"}, 64'd1, 64'd0);
            else check({cur_req, " byte"}, 64'(bus_rdata), 64'(exp_q.pop_front()));
        end
        mon_prev = rd_now;
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model.push_back(8'h00);
        do_reset();
        @(negedge clk);
        check("R10 oe after reset", 64'(bus_oe), 64'd0);

        // Fill the ring; pointer returns to slot 0.
        for (int i = 0; i < 16; i++) do_push(8'h10 + 8'(i));
        check_win("R8 window after fill");

        // R7: pop three, reset, top returns to slot 0 with contents kept.
        for (int i = 0; i < 3; i++) do_pop("R7 pre-reset pop");
        do_reset();
        for (int i = 0; i < 3; i++) model.push_front(model.pop_back());
        check_win("R7 contents kept by reset");

        // R4: bus enable only under chip select and read.
        @(posedge clk); #2; cs_n = 1; rd_n = 0;
        @(negedge clk); check("R4 oe cs high", 64'(bus_oe), 64'd0);
        @(posedge clk); #2; rd_n = 1; cs_n = 0;
        @(negedge clk); check("R4 oe rd high", 64'(bus_oe), 64'd0);
        @(posedge clk); #2; cs_n = 1;
        check_win("R4 no pop without cs");

        // R1: LIFO.
        for (int i = 0; i < 4; i++) do_pop("R1 pop");
        do_push(8'hA0); do_push(8'hA1);
        check_win("R8 window after push");
        do_pop("R1 newest first"); do_pop("R1 next");

        // R5: long strobes act once.
        do_push(8'h55, 5);
        check_win("R5 long push once");
        do_pop("R5 long pop", 6);
        check_win("R5 long pop once");

        // R6: busy blocks both actions.
        do_push(8'h66, 1, 1);
        check_win("R6 busy push ignored");
        do_pop("R6 busy pop shows top", 1, 1);
        check_win("R6 busy pop ignored");

        // R9: command-select strobes ignored.
        do_push(8'h77, 1, 0, 1);
        check_win("R9 command write ignored");
        @(posedge clk); #2; cs_n = 0; sel_cmd = 1; rd_n = 0;
        @(posedge clk); #2; rd_n = 1; cs_n = 1;
        @(posedge clk); #2; sel_cmd = 0;
        check_win("R9 command read ignored");

        // R3: two full rounds give the same sequence.
        for (int i = 0; i < 16; i++) do_pop("R3 round one");
        for (int i = 0; i < 16; i++) do_pop("R3 round two");
        check_win("R3 full circle");

        // R2: 17 pushes drop the first byte.
        for (int i = 0; i < 17; i++) do_push(8'hC0 + 8'(i));
        for (int i = 0; i < 16; i++) do_pop("R2 bottom lost");
        check_win("R2 window");

        repeat (3) @(posedge clk);
        check("R1 monitor queue drained", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule